// File: doc/BRIEF.md
# Double-Buffered Streamer Command Queue

This block sequences a streaming engine that moves words between a memory-side port and a parallel pin bus. Software writes command words through a ready/valid handshake. One command runs at a time and one more can wait behind it, so a driver can queue two commands from idle with no stall. A queued command then starts on the transfer step right after the last word of the running command, with no gap between them.

Each command either drives words from memory onto the pins, captures words from the pins into memory, or holds the bus idle for a set number of transfer steps. A wait command of this kind gives later bus operations the spacing their timing needs. A 32-bit phase accumulator sets the transfer rate: a step occurs on every carry out. Two single-cycle events support interrupt-driven drivers. One fires when the waiting command moves up and the slot frees. The other fires when the engine stops with nothing queued. Each event also has a sticky status copy that software can poll and that clears on read.

Top module: `strm_cmdq`

## Requirements
- R1: From idle, two commands offered on consecutive cycles are both accepted with no stall (`cmd_ready` high for both). The first starts running (`busy` high) and the second waits.
- R2: While a command is waiting, `cmd_ready` is low. An offered command is held off until the slot frees, and no accepted command is ever lost or skipped.
- R3: When a waiting command moves up to running, `evt_empty` is high for exactly one cycle, in the cycle after the step that ended the previous command. It never coincides with `evt_done`.
- R4: When a running command ends, no command is waiting and none is accepted in that cycle, `evt_done` is high for exactly one cycle and `busy` is low in that same cycle.
- R5: Command word layout: bit 30 = capture (1) or drive (0); bits 29:28 = width code (00 wait, 01 8-bit, 10 16-bit, 11 32-bit); bits 15:0 = step count N. The command takes N steps, and N = 0 takes one step. Bits 31 and 27:16 are ignored.
- R6: A wait command (width code 00) runs its steps with `pin_oe` low, with no `mem_rd_take` and with no `mem_wr_put`.
- R7: A drive command asserts `pin_oe` while it runs. On each step it pulses `mem_rd_take` in that cycle, and in the next cycle `pin_out` shows the low 8/16/32 bits of `mem_rd_data`, zero-extended. `pin_out` holds between steps.
- R8: A capture command, on each step, pulses `mem_wr_put` in the next cycle with `mem_wr_data` equal to the low 8/16/32 bits of `pin_in` as they were at the step, zero-extended.
- R9: A step occurs in a busy cycle where the 32-bit phase plus `rate` carries out; the phase takes the sum. The phase is zero during idle, so the first busy cycle starts from zero.
- R10: A command that waits starts on the very next step after the last step of the running command, and no step is lost between them.
- R11: `stat_empty` / `stat_done` go high in the cycle after `evt_empty` / `evt_done` and stay high until a cycle with `stat_rd` high. A new event in that same cycle keeps the bit set.
- R12: After reset the block is idle: `cmd_ready` high, `busy`, `pin_oe`, events, status bits and `pin_out` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_word | input | 32 | Command word (R5 layout) |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| rate | input | 32 | Phase increment per clock |
| mem_rd_data | input | 32 | Next word to drive |
| mem_rd_take | output | 1 | Word consumed this cycle |
| mem_wr_data | output | 32 | Captured word |
| mem_wr_put | output | 1 | Captured word valid |
| pin_in | input | 32 | Pin bus inputs |
| pin_out | output | 32 | Pin bus output values |
| pin_oe | output | 1 | Pin bus output enable |
| busy | output | 1 | A command is running |
| evt_empty | output | 1 | Waiting slot emptied pulse |
| evt_done | output | 1 | Engine stopped pulse |
| stat_rd | input | 1 | Clear sticky status bits |
| stat_empty | output | 1 | Sticky copy of evt_empty |
| stat_done | output | 1 | Sticky copy of evt_done |

## Verification
At full rate, two drive commands issued back to back followed by a third show that seamless chaining works (takes on consecutive cycles) and that a third command is held off. A lone wait command at half rate shows how steps are counted and that the bus stays untouched. A capture whose command word carries stray bits in the ignored fields separates width masking from field decoding. A long random stream, with mixed rates, modes, counts including zero, idle gaps and status reads, makes commands arrive exactly on a command's last step. This separates the direct-to-running path from the waiting path, while a behavioural queue model is compared on every clock.

// File: rtl/strm_pkg.sv
// Shared types and helpers for the streamer command queue.
// Assumes a 32-bit command word and a 32-bit data path.
package strm_pkg;
    localparam int CMD_W  = 32;
    localparam int CNT_W  = 16;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        WID_NONE = 2'b00,
        WID_8    = 2'b01,
        WID_16   = 2'b10,
        WID_32   = 2'b11
    } wid_e;

    typedef struct packed {
        logic             cap;
        wid_e             wid;
        logic [CNT_W-1:0] cnt;
    } cmd_t;

    // Pull the used fields out of a raw command word.
    function automatic cmd_t decode(input logic [CMD_W-1:0] w);
        cmd_t c;
        c.cap = w[30];
        c.wid = wid_e'(w[29:28]);
        c.cnt = w[CNT_W-1:0];
        return c;
    endfunction

    // Steps remaining after the first one (count 0 behaves as 1).
    function automatic logic [CNT_W-1:0] first_left(input cmd_t c);
        return (c.cnt == '0) ? '0 : c.cnt - 1'b1;
    endfunction

    // Keep the low 8/16/32 bits of a word, zero-extended.
    function automatic logic [DATA_W-1:0] lane_mask(input wid_e wd, input logic [DATA_W-1:0] d);
        case (wd)
            WID_8:   return {{(DATA_W-8){1'b0}},  d[7:0]};
            WID_16:  return {{(DATA_W-16){1'b0}}, d[15:0]};
            WID_32:  return d;
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/strm_rate.sv
// Transfer-rate gate: a phase accumulator that steps on carry out.
// Assumes run is high exactly while a command is active; phase is zero when idle.
module strm_rate #(
    parameter int PH_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [PH_W-1:0] rate,
    output logic            step
);
    logic [PH_W-1:0] phase;
    logic [PH_W:0]   sum;

    // Phase plus increment, carry in the top bit.
    always_comb sum = {1'b0, phase} + {1'b0, rate};

    assign step = run & sum[PH_W];

    // Advance the phase while running, clear it while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)   phase <= '0;
        else if (run) phase <= sum[PH_W-1:0];
        else          phase <= '0;
    end

    // R9
    idle_then_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !step);
endmodule

// File: rtl/strm_slots.sv
// Active and pending command slots with the two event pulses.
// Assumes step only matters while a command is active.
module strm_slots
    import strm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_word,
    output logic             cmd_ready,
    input  logic             step,
    output logic             act_vld,
    output cmd_t             act_c,
    output logic             evt_empty,
    output logic             evt_done
);
    logic             pend_vld;
    cmd_t             pend_c;
    logic [CNT_W-1:0] left;
    cmd_t             in_c;
    logic             take_in, fin, to_act;

    // Decode the incoming word and work out where it lands.
    always_comb begin
        in_c      = decode(cmd_word);
        cmd_ready = !pend_vld;
        take_in   = cmd_valid && cmd_ready;
        fin       = step && act_vld && (left == '0);
        to_act    = take_in && (!act_vld || (fin && !pend_vld));
    end

    // Slot state: load, count down, promote, retire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_vld  <= 1'b0;
            pend_vld <= 1'b0;
            act_c    <= '0;
            pend_c   <= '0;
            left     <= '0;
        end else begin
            if (fin && pend_vld) begin
                act_c    <= pend_c;
                left     <= first_left(pend_c);
                pend_vld <= 1'b0;
            end else if (to_act) begin
                act_vld <= 1'b1;
                act_c   <= in_c;
                left    <= first_left(in_c);
            end else if (fin) begin
                act_vld <= 1'b0;
            end else if (step && act_vld) begin
                left <= left - 1'b1;
            end
            if (take_in && !to_act) begin
                pend_c   <= in_c;
                pend_vld <= 1'b1;
            end
        end
    end

    // Event pulses, one cycle after the finishing step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_empty <= 1'b0;
            evt_done  <= 1'b0;
        end else begin
            evt_empty <= fin && pend_vld;
            evt_done  <= fin && !pend_vld && !to_act;
        end
    end

    // R2
    pend_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_vld && !fin) |=> pend_vld);
    // R3
    empty_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_empty |-> (act_vld && !pend_vld));
    // R3
    evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_empty && evt_done));
    // R4
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_done |-> !act_vld);
endmodule

// File: rtl/strm_lanes.sv
// Pin-side data path: drives or captures one masked word per step.
// Assumes memory supplies the next word combinationally on mem_rd_data.
module strm_lanes
    import strm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              act_vld,
    input  cmd_t              act_c,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_take,
    input  logic [DATA_W-1:0] pin_in,
    output logic [DATA_W-1:0] pin_out,
    output logic              pin_oe,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_put
);
    logic is_out, is_in;

    // Classify the active command.
    always_comb begin
        is_out  = act_vld && (act_c.wid != WID_NONE) && !act_c.cap;
        is_in   = act_vld && (act_c.wid != WID_NONE) &&  act_c.cap;
        rd_take = step && is_out;
        pin_oe  = is_out;
    end

    // Output register updated on each drive step.
    always_ff @(posedge clk) begin
        if (!rst_n)       pin_out <= '0;
        else if (rd_take) pin_out <= lane_mask(act_c.wid, rd_data);
    end

    // Capture register and its valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_data <= '0;
            wr_put  <= 1'b0;
        end else begin
            wr_put <= step && is_in;
            if (step && is_in) wr_data <= lane_mask(act_c.wid, pin_in);
        end
    end

    // R8
    put_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_put |-> $past(step));
endmodule

// File: rtl/strm_cmdq.sv
// Streamer command queue top: slots, rate gate, data lanes, sticky status.
// Assumes stat_rd is a one-cycle read strobe from the register front end.
module strm_cmdq
    import strm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [31:0] cmd_word,
    output logic        cmd_ready,
    input  logic [31:0] rate,
    input  logic [31:0] mem_rd_data,
    output logic        mem_rd_take,
    output logic [31:0] mem_wr_data,
    output logic        mem_wr_put,
    input  logic [31:0] pin_in,
    output logic [31:0] pin_out,
    output logic        pin_oe,
    output logic        busy,
    output logic        evt_empty,
    output logic        evt_done,
    input  logic        stat_rd,
    output logic        stat_empty,
    output logic        stat_done
);
    logic act_vld, step;
    cmd_t act_c;

    strm_slots u_slots (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_word(cmd_word), .cmd_ready(cmd_ready),
        .step(step), .act_vld(act_vld), .act_c(act_c),
        .evt_empty(evt_empty), .evt_done(evt_done)
    );

    strm_rate #(.PH_W(32)) u_rate (
        .clk(clk), .rst_n(rst_n), .run(act_vld), .rate(rate), .step(step)
    );

    strm_lanes u_lanes (
        .clk(clk), .rst_n(rst_n), .step(step),
        .act_vld(act_vld), .act_c(act_c),
        .rd_data(mem_rd_data), .rd_take(mem_rd_take),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .wr_data(mem_wr_data), .wr_put(mem_wr_put)
    );

    assign busy = act_vld;

    // Sticky status: set by an event pulse, cleared by a read, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_empty <= 1'b0;
            stat_done  <= 1'b0;
        end else begin
            stat_empty <= (stat_empty && !stat_rd) || evt_empty;
            stat_done  <= (stat_done  && !stat_rd) || evt_done;
        end
    end

    // R11
    sticky_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_empty |=> stat_empty);
    // R11
    sticky_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_done |=> stat_done);
endmodule

// File: tb/test_strm_cmdq.sv
// Bench: behavioural queue model compared with the design on every clock.
module test_strm_cmdq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_word = '0;
    logic        cmd_ready;
    logic [31:0] rate = 32'hFFFF_FFFF;
    logic [31:0] mem_rd_data;
    logic        mem_rd_take;
    logic [31:0] mem_wr_data;
    logic        mem_wr_put;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic        pin_oe, busy, evt_empty, evt_done;
    logic        stat_rd = 1'b0;
    logic        stat_empty, stat_done;

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [31:0] rdcnt = '0;
    assign mem_rd_data = 32'h3C00_0000 ^ (rdcnt * 32'h0101_0103);

    always #10 clk = ~clk;

    strm_cmdq i_strm_cmdq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .cmd_ready(cmd_ready), .rate(rate), .mem_rd_data(mem_rd_data),
        .mem_rd_take(mem_rd_take), .mem_wr_data(mem_wr_data), .mem_wr_put(mem_wr_put),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .busy(busy),
        .evt_empty(evt_empty), .evt_done(evt_done), .stat_rd(stat_rd),
        .stat_empty(stat_empty), .stat_done(stat_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // ---------------- reference model ----------------
    logic [31:0] q[$];
    int          left = 0;
    logic [31:0] m_acc = '0, m_pin_out = '0, m_wdata = '0;
    logic        m_put = 0, m_ee = 0, m_ed = 0, m_se = 0, m_sd = 0;

    function automatic logic [31:0] msk(input logic [1:0] wd, input logic [31:0] d);
        if (wd == 2'd1) return d & 32'hFF;
        if (wd == 2'd2) return d & 32'hFFFF;
        if (wd == 2'd3) return d;
        return 32'h0;
    endfunction
    function automatic int steps_after_first(input logic [31:0] w);
        return (w[15:0] == 0) ? 0 : int'(w[15:0]) - 1;
    endfunction
    function automatic bit m_step();
        logic [32:0] s = {1'b0, m_acc} + {1'b0, rate};
        return (q.size() > 0) && s[32];
    endfunction
    function automatic bit m_out();
        return (q.size() > 0) && (q[0][29:28] != 2'b00) && !q[0][30];
    endfunction
    function automatic bit m_in();
        return (q.size() > 0) && (q[0][29:28] != 2'b00) && q[0][30];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); left = 0; m_acc = '0; m_pin_out = '0; m_wdata = '0;
            m_put = 0; m_ee = 0; m_ed = 0; m_se = 0; m_sd = 0;
        end else begin
            bit st, fin, acc_in; int sz; logic [32:0] s;
            s = {1'b0, m_acc} + {1'b0, rate};
            st = m_step();
            if (st && m_out()) begin
                m_pin_out = msk(q[0][29:28], mem_rd_data);
                rdcnt <= rdcnt + 1;
            end
            m_put = st && m_in();
            if (m_put) m_wdata = msk(q[0][29:28], pin_in);
            fin = st && (left == 0);
            if (st && !fin) left--;
            sz = q.size();
            acc_in = cmd_valid && (sz < 2);
            m_se = (m_se && !stat_rd) || m_ee;
            m_sd = (m_sd && !stat_rd) || m_ed;
            m_ee = fin && (sz == 2);
            m_ed = fin && (sz == 1) && !acc_in;
            m_acc = (sz > 0) ? s[31:0] : 32'h0;
            if (fin) void'(q.pop_front());
            if (acc_in) q.push_back(cmd_word);
            if ((fin || sz == 0) && q.size() > 0) left = steps_after_first(q[0]);
        end
    end

    // Event monitor counters used by the scenario checks.
    int n_ee = 0, n_ed = 0, n_take = 0, n_put = 0, n_busy = 0, first_take = -1, last_take = -1;
    logic [31:0] last_wdata = '0;

    // Per-clock comparison, sampled at the falling edge.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk(cmd_ready == (q.size() < 2), "R2", "cmd_ready", cmd_ready, q.size() < 2);
            chk(busy == (q.size() > 0), "R4", "busy", busy, q.size() > 0);
            chk(evt_empty == m_ee, "R3", "evt_empty", evt_empty, m_ee);
            chk(evt_done == m_ed, "R4", "evt_done", evt_done, m_ed);
            chk(pin_oe == m_out(), "R7", "pin_oe", pin_oe, m_out());
            chk(mem_rd_take == (m_step() && m_out()), "R9", "mem_rd_take", mem_rd_take, m_step() && m_out());
            chk(pin_out == m_pin_out, "R7", "pin_out", pin_out, m_pin_out);
            chk(mem_wr_put == m_put, "R8", "mem_wr_put", mem_wr_put, m_put);
            if (m_put) chk(mem_wr_data == m_wdata, "R8", "mem_wr_data", mem_wr_data, m_wdata);
            chk(stat_empty == m_se, "R11", "stat_empty", stat_empty, m_se);
            chk(stat_done == m_sd, "R11", "stat_done", stat_done, m_sd);
            if (evt_empty) n_ee++;
            if (evt_done) n_ed++;
            if (mem_rd_take) begin
                n_take++;
                if (first_take < 0) first_take = cyc;
                last_take = cyc;
            end
            if (mem_wr_put) begin n_put++; last_wdata = mem_wr_data; end
            if (busy) n_busy++;
        end
    end

    task automatic clr_counts();
        n_ee = 0; n_ed = 0; n_take = 0; n_put = 0; n_busy = 0; first_take = -1; last_take = -1;
    endtask

    // Offer one command; returns the cycles spent offering it.
    task automatic send(input logic [31:0] w, output int waited);
        bit r;
        waited = 0;
        cmd_word = w; cmd_valid = 1'b1;
        forever begin
            r = cmd_ready;
            waited++;
            @(negedge clk); #1;
            if (r) break;
        end
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000; i++) begin
            if (!busy && !cmd_valid) break;
            @(negedge clk); #1;
        end
        @(negedge clk); #1;
        @(negedge clk); #1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        int w1, w2, w3;
        repeat (3) @(negedge clk);
        #1;
        // R12: reset state
        chk(cmd_ready === 1'b1, "R12", "cmd_ready at reset", cmd_ready, 1);
        chk(busy === 1'b0 && pin_oe === 1'b0, "R12", "busy/pin_oe at reset", {busy, pin_oe}, 0);
        chk(pin_out === 32'h0 && evt_empty === 1'b0 && evt_done === 1'b0, "R12", "outputs at reset", pin_out, 0);
        chk(stat_empty === 1'b0 && stat_done === 1'b0, "R12", "status at reset", {stat_empty, stat_done}, 0);
        @(negedge clk); rst_n = 1'b1; #1;

        // R1, R2, R10: back to back drives at full rate, then a third held off
        clr_counts();
        rate = 32'hFFFF_FFFF;
        send(32'h1000_0003, w1);
        send(32'h2000_0002, w2);
        chk(w1 == 1 && w2 == 1, "R1", "cycles to accept two commands", w1 + w2, 2);
        chk(cmd_ready == 1'b0 && busy == 1'b1, "R2", "ready with both slots full", cmd_ready, 0);
        send(32'h0000_0001, w3);
        chk(w3 > 1, "R2", "third command stalled", w3 > 1, 1);
        wait_idle();
        chk(n_take == 5, "R7", "words taken", n_take, 5);
        chk(last_take - first_take == 4, "R10", "take span", last_take - first_take, 4);
        chk(n_ee == 2, "R3", "empty events", n_ee, 2);
        chk(n_ed == 1, "R4", "done events", n_ed, 1);

        // R11: sticky bits clear on read
        chk(stat_empty && stat_done, "R11", "sticky set", {stat_empty, stat_done}, 2'b11);
        stat_rd = 1'b1; @(negedge clk); #1; stat_rd = 1'b0;
        chk(!stat_empty && !stat_done, "R11", "sticky cleared", {stat_empty, stat_done}, 0);

        // R6, R9: lone wait of 4 steps at half rate
        clr_counts();
        rate = 32'h8000_0000;
        send(32'h0000_0004, w1);
        wait_idle();
        chk(n_take == 0 && n_put == 0, "R6", "traffic during wait", n_take + n_put, 0);
        chk(n_busy == 8, "R9", "busy cycles for 4 half-rate steps", n_busy, 8);

        // R5, R8: capture 16 with stray bits in ignored fields
        clr_counts();
        rate = 32'hFFFF_FFFF;
        pin_in = 32'hDEAD_BEEF;
        send(32'hEABC_0001, w1);
        wait_idle();
        chk(n_put == 1, "R5", "one capture for count 1 with stray bits", n_put, 1);
        chk(last_wdata == 32'h0000_BEEF, "R8", "captured 16-bit word", last_wdata, 32'h0000_BEEF);

        // R5: count 0 runs one step
        clr_counts();
        pin_in = 32'h1234_5678;
        send(32'h5000_0000, w1);
        wait_idle();
        chk(n_put == 1 && last_wdata == 32'h78, "R5", "count zero capture", last_wdata, 32'h78);

        // Random stream: mixed rates, modes, counts, gaps and status reads
        for (int k = 0; k < 300; k++) begin
            int gap, r;
            r = $urandom % 4;
            rate = (r == 0) ? 32'hFFFF_FFFF : (r == 1) ? 32'h8000_0000 :
                   (r == 2) ? 32'h5555_5555 : 32'hC000_0000;
            pin_in = $urandom;
            stat_rd = ($urandom % 5 == 0);
            send({$urandom} & 32'hFFFF_0003 | ((k % 3 == 0) ? 32'h0 : 32'h0), w1);
            stat_rd = 1'b0;
            gap = $urandom % 4;
            for (int g = 0; g < gap; g++) begin @(negedge clk); #1; end
        end
        wait_idle();
        chk(!busy && cmd_ready, "R4", "idle after random stream", busy, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule